// File: doc/BRIEF.md
# Three-Register Load and Rotate Unit

This block keeps three byte-wide registers, named A, B and C, which all take data from one shared input byte. Each register has its own write strobe. Any subset of the strobes may be high in the same cycle. A rotate command shifts the three values around a ring in a single clock: A takes B, B takes C and C takes A. The rotate wins over every write strobe. A synchronous reset clears all three registers and wins over everything else. All three register values come out on their own output buses in every cycle.

Inside, a small decoder sorts each cycle into one of four named operations:

- `OP_CLEAR`: reset is high.
- `OP_ROTATE`: rotate is high and reset is low.
- `OP_LOAD`: at least one strobe is high, and neither reset nor rotate is.
- `OP_HOLD`: nothing is requested.

The operation moves directly between any two of these from one cycle to the next, so every transition between them is allowed. One slot module per register then picks that register's next value from the decoded operation.

Top module: `trio_rotreg`

## Requirements
- R1: When `rst` is high at a rising edge, all three outputs are 0x00 after that edge, whatever the values of `rot`, the strobes and `din`.
- R2: When `ld_a` is high and `rot` and `rst` are low at a rising edge, `q_a` equals the `din` value sampled at that edge. The same holds for `ld_b` with `q_b` and for `ld_c` with `q_c`.
- R3: The strobes act independently. Any combination of `ld_a`, `ld_b` and `ld_c` (written as {c,b,a}, bit 0 = A) loads exactly the registers whose strobe is high, in the same edge.
- R4: When `rot` is high and `rst` is low at a rising edge, the new `q_a` is the old `q_b`, the new `q_b` is the old `q_c`, and the new `q_c` is the old `q_a`. All three take values from before the edge.
- R5: While `rot` is high, the strobes and `din` have no effect on any register in that cycle.
- R6: A register whose strobe is low keeps its value when `rot` and `rst` are low.
- R7: Three rotate cycles in a row, with no reset, return all three registers to their values from before the first rotate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous active-high clear, top priority |
| din | input | 8 | Shared write data |
| ld_a | input | 1 | Write strobe for register A |
| ld_b | input | 1 | Write strobe for register B |
| ld_c | input | 1 | Write strobe for register C |
| rot | input | 1 | Ring rotate command, overrides strobes |
| q_a | output | 8 | Current value of register A |
| q_b | output | 8 | Current value of register B |
| q_c | output | 8 | Current value of register C |

## Verification
The two functions that can fall in the same cycle are a write through any strobe and the ring rotate. Reset can also coincide with both of them. The bench first sets the registers to distinct known bytes. It then drives every one of the eight strobe patterns once with `rot` low and once with `rot` high, and later mixes random strobes, rotates and occasional resets. A reference model applies the priority clear > rotate > load > hold and predicts each register. Any register that shows `din` during a rotate cycle, or that failed to take the neighbour's old value, is reported against R5 or R4.

// File: rtl/trio_pkg.sv
package trio_pkg;
    localparam int DATA_W = 8;
    localparam int NREG   = 3;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_ROTATE = 2'd2,
        OP_CLEAR  = 2'd3
    } op_e;
endpackage

// File: rtl/trio_op_decode.sv
module trio_op_decode
    import trio_pkg::*;
#(
    parameter int N = NREG
) (
    input  logic         rst,
    input  logic         rot,
    input  logic [N-1:0] ld,
    output op_e          op
);
    // Fixed priority: clear, then rotate, then any load, else hold.
    always_comb begin
        if (rst)
            op = OP_CLEAR;
        else if (rot)
            op = OP_ROTATE;
        else if (|ld)
            op = OP_LOAD;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/trio_slot.sv
module trio_slot
    import trio_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  op_e          op,
    input  logic         ld,
    input  logic [W-1:0] din,
    input  logic [W-1:0] nbr,
    output logic [W-1:0] q
);
    logic [W-1:0] q_nxt;

    always_comb begin
        unique case (op)
            OP_CLEAR:  q_nxt = '0;
            OP_ROTATE: q_nxt = nbr;
            OP_LOAD:   q_nxt = ld ? din : q;
            OP_HOLD:   q_nxt = q;
            default:   q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= q_nxt;
    end
endmodule

// File: rtl/trio_rotreg.sv
module trio_rotreg
    import trio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              ld_a,
    input  logic              ld_b,
    input  logic              ld_c,
    input  logic              rot,
    output logic [DATA_W-1:0] q_a,
    output logic [DATA_W-1:0] q_b,
    output logic [DATA_W-1:0] q_c
);
    op_e              op;
    logic [NREG-1:0]  ld_vec;
    word_t            regs [NREG];

    assign ld_vec = {ld_c, ld_b, ld_a};

    trio_op_decode #(.N(NREG)) dec_i (
        .rst (rst),
        .rot (rot),
        .ld  (ld_vec),
        .op  (op)
    );

    // Slot i rotates in from slot i+1 (wrapping), giving A<-B, B<-C, C<-A.
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        localparam int NXT = (i + 1) % NREG;
        trio_slot #(.W(DATA_W)) slot_i (
            .clk (clk),
            .op  (op),
            .ld  (ld_vec[i]),
            .din (din),
            .nbr (regs[NXT]),
            .q   (regs[i])
        );
    end

    assign q_a = regs[0];
    assign q_b = regs[1];
    assign q_c = regs[2];
endmodule

// File: rtl/trio_rotreg_chk.sv
module trio_rotreg_chk
    import trio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] din,
    input logic              ld_a,
    input logic              ld_b,
    input logic              ld_c,
    input logic              rot,
    input logic [DATA_W-1:0] q_a,
    input logic [DATA_W-1:0] q_b,
    input logic [DATA_W-1:0] q_c
);
    p_clear_r1: assert property (@(posedge clk)
        rst |=> (q_a == '0 && q_b == '0 && q_c == '0));

    p_load_a_r2: assert property (@(posedge clk) disable iff (rst)
        (!rot && ld_a) |=> q_a == $past(din));

    p_load_pair_r3: assert property (@(posedge clk) disable iff (rst)
        (!rot && ld_b && ld_c) |=> (q_b == $past(din) && q_c == $past(din)));

    p_rotate_r4: assert property (@(posedge clk) disable iff (rst)
        rot |=> (q_a == $past(q_b) && q_b == $past(q_c) && q_c == $past(q_a)));

    p_rot_over_load_r5: assert property (@(posedge clk) disable iff (rst)
        (rot && (ld_a || ld_b || ld_c) && din != q_b) |=> q_a != $past(din));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!rot && !ld_a && !ld_b && !ld_c) |=> ($stable(q_a) && $stable(q_b) && $stable(q_c)));

    p_triple_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(rot, 1) && $past(rot, 2) && $past(rot, 3) &&
         !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
        |-> (q_a == $past(q_a, 3) && q_b == $past(q_b, 3) && q_c == $past(q_c, 3)));
endmodule

bind trio_rotreg trio_rotreg_chk chk_i (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .ld_a (ld_a),
    .ld_b (ld_b),
    .ld_c (ld_c),
    .rot  (rot),
    .q_a  (q_a),
    .q_b  (q_b),
    .q_c  (q_c)
);

// File: tb/trio_rotreg_tb_top.sv
module trio_rotreg_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = 8'h00;
    logic       ld_a = 1'b0, ld_b = 1'b0, ld_c = 1'b0, rot = 1'b0;
    logic [7:0] q_a, q_b, q_c;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] m_a = 8'h00, m_b = 8'h00, m_c = 8'h00;

    always #5 clk = ~clk;

    trio_rotreg dut_i (
        .clk(clk), .rst(rst), .din(din),
        .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c), .rot(rot),
        .q_a(q_a), .q_b(q_b), .q_c(q_c)
    );

    function automatic string tag_for(input logic r, input logic ro,
                                      input logic [2:0] l, input int idx);
        if (r)         return "R1";
        if (ro)        return (l != 3'b000) ? "R5" : "R4";
        if (!l[idx])   return "R6";
        if ($countones(l) > 1) return "R3";
        return "R2";
    endfunction

    function automatic logic [23:0] model_next(input logic r, input logic ro,
                                               input logic [2:0] l, input logic [7:0] d,
                                               input logic [7:0] a, input logic [7:0] b,
                                               input logic [7:0] c);
        if (r)  return 24'h0;
        if (ro) return {a, c, b};          // {C,B,A} = {old A, old C, old B}
        return {l[2] ? d : c, l[1] ? d : b, l[0] ? d : a};
    endfunction

    task automatic check(input string tag, input string nm,
                         input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, nm, got, exp);
        end
    endtask

    task automatic apply(input logic r, input logic ro,
                         input logic [2:0] l, input logic [7:0] d);
        logic [23:0] nx;
        @(negedge clk);
        rst = r; rot = ro; {ld_c, ld_b, ld_a} = l; din = d;
        @(posedge clk);
        nx = model_next(r, ro, l, d, m_a, m_b, m_c);
        {m_c, m_b, m_a} = nx;
        #2;
        check(tag_for(r, ro, l, 0), "q_a", q_a, m_a);
        check(tag_for(r, ro, l, 1), "q_b", q_b, m_b);
        check(tag_for(r, ro, l, 2), "q_c", q_c, m_c);
    endtask

    task automatic preset(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        apply(1'b0, 1'b0, 3'b001, a);
        apply(1'b0, 1'b0, 3'b010, b);
        apply(1'b0, 1'b0, 3'b100, c);
    endtask

    logic done = 1'b0;

    initial begin
        #(1_500_000ns);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] s_a, s_b, s_c;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));

        // R1: reset wins over rotate, loads and data
        apply(1'b1, 1'b1, 3'b111, 8'hFF);
        apply(1'b1, 1'b0, 3'b000, 8'h00);

        // R2/R3/R6 and R4/R5: every strobe pattern with and without rotate
        for (int ro = 0; ro < 2; ro++) begin
            for (int l = 0; l < 8; l++) begin
                preset(8'h11, 8'h22, 8'h33);
                apply(1'b0, ro[0], l[2:0], 8'hA5);
            end
        end

        // R7: three rotates return the start values
        preset(8'h5A, 8'hC3, 8'h0F);
        s_a = q_a; s_b = q_b; s_c = q_c;
        repeat (3) apply(1'b0, 1'b1, 3'b000, 8'h00);
        check("R7", "q_a", q_a, s_a);
        check("R7", "q_b", q_b, s_b);
        check("R7", "q_c", q_c, s_c);

        // R7 with strobes active during the rotates (still ignored, R5)
        repeat (3) apply(1'b0, 1'b1, 3'b111, 8'hEE);
        check("R7", "q_a", q_a, s_a);
        check("R7", "q_b", q_b, s_b);
        check("R7", "q_c", q_c, s_c);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic r, ro;
            logic [2:0] l;
            logic [7:0] d;
            r  = ($urandom % 40) == 0;
            ro = ($urandom % 3) == 0;
            l  = 3'($urandom);
            d  = 8'($urandom);
            apply(r, ro, l, d);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule